// File: doc/BRIEF.md
# I2C Slave Address Matcher with Bit Masking

This block decides whether an I2C slave is being addressed. The bit-level receiver in front of it marks each START or repeated START with `start_det` and hands over each received byte with a one-cycle `byte_vld` strobe. The matcher compares the address carried by the first byte, or by the first two bytes in 10-bit mode, against a programmed own address.

Selected address bits can be left out of the compare, so that one slave answers a whole group of addresses. The matcher also recognises the all-zero general call address, but only when that feature is switched on. Its results are single-cycle pulses that the surrounding slave logic uses to acknowledge the address and to raise an interrupt. Bit shifting, clock stretching and the data phase are handled elsewhere.

Top module: `i2c_addr_match`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `addr_match`, `gcall_hit` and `irq` are low. A byte strobed after reset and before any `start_det` produces no output.
- R2: In 7-bit mode (`ten_bit`=0), `byte_in[7:1]` is compared with `own_addr[6:0]`. `byte_in[0]` is the direction bit and is never compared. On a match, `addr_match` is high for exactly the one cycle after the strobe.
- R3: `mask_sel[k]` (k = 0..4) removes address bit k+1 from the compare. Address bit 6 in 7-bit mode, and bits 7 and 6 of the low byte in 10-bit mode, are always compared.
- R4: In 7-bit mode, `mask_sel[0]` removes only address bit 1. Address bit 0 (`byte_in[1]`) is always compared.
- R5: In 10-bit mode, the first byte must equal `11110` in `byte_in[7:3]` and `own_addr[9:8]` in `byte_in[2:1]`. This part is never maskable, and `byte_in[0]` is ignored. The second byte is then compared with `own_addr[7:0]` under the mask, and `mask_sel[0]` removes both bit 1 and bit 0. `addr_match` pulses only in the cycle after the second byte.
- R6: A first byte with `byte_in[7:1]`=0 pulses `gcall_hit` in the cycle after the strobe when `gcall_en` is 1, and gives no output when it is 0. The all-zero address never produces `addr_match`.
- R7: With `slave_en`=0, all mask bits act as 0 and the general call is never recognised.
- R8: Only the first byte (7-bit mode) or the first two bytes (10-bit mode) after a `start_det` are examined. Any later byte produces no output until the next `start_det`.
- R9: `irq` is high in exactly the cycles where `addr_match` or `gcall_hit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | START or repeated START seen; the next byte is the first |
| byte_vld | input | 1 | One-cycle strobe for `byte_in` |
| byte_in | input | 8 | Received byte, MSB first on the bus |
| ten_bit | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| slave_en | input | 1 | Masks and general call are active only when 1 |
| own_addr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| mask_sel | input | 5 | Bit k excludes address bit k+1 from the compare |
| gcall_en | input | 1 | Enable general call recognition |
| addr_match | output | 1 | Pulse: own address matched |
| gcall_hit | output | 1 | Pulse: general call received |
| irq | output | 1 | Pulse: interrupt request for either event |

## Verification
In 7-bit mode, every address byte is tried, with both direction bits, under all 32 mask settings. This separates masked bits from compared bits, shows that the direction bit is ignored, and shows that the lowest mask covers one bit only. In 10-bit mode, every second byte is tried under all mask settings, which shows that the lowest mask covers two bits. Every possible first byte is also tried against a correct second byte, which shows that the header can never be masked. Separate directed frames cover general call with the enable on and off, slave mode off, bytes beyond the address phase, and a byte with no START before it.

// File: rtl/i2c_amatch_pkg.sv
package i2c_amatch_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  localparam logic [4:0] TEN_HDR = 5'b11110;
endpackage

// File: rtl/amatch_care.sv
// Builds the per-bit compare enable of the byte-wide address lane.
module amatch_care #(
  parameter int MASK_N = 5,
  parameter int CARE_W = 8
) (
  input  logic [MASK_N-1:0] mask,
  input  logic              ten_bit,
  output logic [CARE_W-1:0] care
);
  for (genvar i = 0; i < CARE_W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      // bit 0 only joins the lowest mask in 10-bit mode
      assign care[i] = ~(ten_bit & mask[0]);
    end else if (i <= MASK_N) begin : g_mask
      assign care[i] = ~mask[i-1];
    end else begin : g_fixed
      assign care[i] = 1'b1;
    end
  end
endmodule

// File: rtl/amatch_cmp.sv
module amatch_cmp #(
  parameter int ADDR_W = 10,
  parameter int CARE_W = 8
) (
  input  logic [7:0]        byte_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [CARE_W-1:0] care,
  output logic              hit7,
  output logic              hdr_ok,
  output logic              hit10,
  output logic              gc_pat
);
  import i2c_amatch_pkg::*;

  localparam int A7_W = 7;

  logic [A7_W-1:0] diff7;
  logic [7:0]      diff10;

  always_comb begin
    diff7  = (byte_in[7:1] ^ own_addr[A7_W-1:0]) & care[A7_W-1:0];
    diff10 = (byte_in ^ own_addr[7:0]) & care;
    gc_pat = (byte_in[7:1] == '0);
    hit7   = (diff7 == '0) && !gc_pat;
    hdr_ok = (byte_in[7:3] == TEN_HDR) && (byte_in[2:1] == own_addr[ADDR_W-1:ADDR_W-2]);
    hit10  = (diff10 == '0);
  end
endmodule

// File: rtl/amatch_phase.sv
module amatch_phase
  import i2c_amatch_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_det,
  input  logic   byte_vld,
  input  logic   ten_bit,
  input  logic   hdr_ok,
  output phase_e phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
    end else if (start_det) begin
      phase <= PH_FIRST;
    end else if (byte_vld) begin
      unique case (phase)
        PH_FIRST: phase <= (ten_bit && hdr_ok) ? PH_SECOND : PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_amatch_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int MASK_N = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              ten_bit,
  input  logic              slave_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [MASK_N-1:0] mask_sel,
  input  logic              gcall_en,
  output logic              addr_match,
  output logic              gcall_hit,
  output logic              irq
);
  localparam int CARE_W = 8;

  phase_e            phase;
  logic [MASK_N-1:0] mask_eff;
  logic [CARE_W-1:0] care;
  logic              hit7, hdr_ok, hit10, gc_pat;
  logic              take, match_d, gc_d;

  assign mask_eff = slave_en ? mask_sel : '0;

  amatch_care #(.MASK_N(MASK_N), .CARE_W(CARE_W)) u_care (
    .mask(mask_eff), .ten_bit(ten_bit), .care(care)
  );

  amatch_cmp #(.ADDR_W(ADDR_W), .CARE_W(CARE_W)) u_cmp (
    .byte_in(byte_in), .own_addr(own_addr), .care(care),
    .hit7(hit7), .hdr_ok(hdr_ok), .hit10(hit10), .gc_pat(gc_pat)
  );

  amatch_phase u_phase (
    .clk(clk), .rst(rst), .start_det(start_det), .byte_vld(byte_vld),
    .ten_bit(ten_bit), .hdr_ok(hdr_ok), .phase(phase)
  );

  always_comb begin
    take    = byte_vld && !start_det;
    match_d = take && (((phase == PH_FIRST) && !ten_bit && hit7) ||
                       ((phase == PH_SECOND) && hit10));
    gc_d    = take && (phase == PH_FIRST) && gc_pat && gcall_en && slave_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_match <= 1'b0;
      gcall_hit  <= 1'b0;
      irq        <= 1'b0;
    end else begin
      addr_match <= match_d;
      gcall_hit  <= gc_d;
      irq        <= match_d | gc_d;
    end
  end
endmodule

// File: rtl/i2c_amatch_chk.sv
module i2c_amatch_chk (
  input logic clk,
  input logic rst,
  input logic byte_vld,
  input logic gcall_en,
  input logic slave_en,
  input logic addr_match,
  input logic gcall_hit,
  input logic irq
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!addr_match && !gcall_hit && !irq));
  a_r2_match_single: assert property (@(posedge clk) disable iff (rst)
    addr_match |=> !addr_match);
  a_r2_match_after_strobe: assert property (@(posedge clk) disable iff (rst)
    addr_match |-> $past(byte_vld));
  a_r6_gc_needs_enable: assert property (@(posedge clk) disable iff (rst)
    gcall_hit |-> $past(gcall_en && slave_en && byte_vld));
  a_r6_zero_not_own: assert property (@(posedge clk) disable iff (rst)
    !(addr_match && gcall_hit));
  a_r9_irq_on_event: assert property (@(posedge clk) disable iff (rst)
    (addr_match || gcall_hit) |-> irq);
  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> (addr_match || gcall_hit));
endmodule

bind i2c_addr_match i2c_amatch_chk u_chk (.*);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_det = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = '0;
  logic       ten_bit = 1'b0;
  logic       slave_en = 1'b1;
  logic [9:0] own_addr = '0;
  logic [4:0] mask_sel = '0;
  logic       gcall_en = 1'b0;
  logic       addr_match, gcall_hit, irq;

  int total = 0;
  int bad = 0;
  logic [2:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_match u_dut (
    .clk(clk), .rst(rst), .start_det(start_det), .byte_vld(byte_vld),
    .byte_in(byte_in), .ten_bit(ten_bit), .slave_en(slave_en),
    .own_addr(own_addr), .mask_sel(mask_sel), .gcall_en(gcall_en),
    .addr_match(addr_match), .gcall_hit(gcall_hit), .irq(irq)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s {match,gc,irq} got=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  // strobe one byte and capture outputs one cycle later
  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_in = b;
    @(negedge clk); byte_vld = 1'b0;
    got = {addr_match, gcall_hit, irq};
  endtask

  function automatic logic [2:0] exp7(input logic [7:0] b, input logic [6:0] own,
                                     input logic [4:0] m, input logic ge);
    logic [6:0] a = b[7:1];
    logic [6:0] care = ~{1'b0, m, 1'b0};
    logic em = (((a ^ own) & care) == '0) && (a != '0);
    logic eg = (a == '0) && ge;
    return {em, eg, em | eg};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {addr_match, gcall_hit, irq}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {addr_match, gcall_hit, irq}, 3'b000);
    own_addr = 10'h05A;
    send(8'hB4);
    chk("R1 byte before any start", got, 3'b000);

    // 7-bit sweep: all bytes under every mask (R2 R3 R4 R6)
    for (int o = 0; o < 2; o++) begin
      own_addr = (o == 0) ? 10'h05A : 10'h027;
      for (int m = 0; m < 32; m++) begin
        if (o == 1 && m != 0 && m != 31) continue;
        mask_sel = m[4:0];
        gcall_en = m[0];
        for (int b = 0; b < 256; b++) begin
          do_start();
          send(b[7:0]);
          chk("R2 R3 R4 R6 R9 7-bit sweep", got,
              exp7(b[7:0], own_addr[6:0], m[4:0], m[0]));
        end
      end
    end

    // single-cycle pulse (R2) and later bytes ignored (R8)
    own_addr = 10'h05A; mask_sel = '0; gcall_en = 1'b1;
    do_start();
    send(8'hB5);
    chk("R2 match pulse", got, 3'b101);
    @(negedge clk);
    chk("R2 pulse is one cycle", {addr_match, gcall_hit, irq}, 3'b000);
    send(8'hB4);
    chk("R8 second byte in 7-bit ignored", got, 3'b000);
    send(8'h00);
    chk("R8 zero byte after address ignored", got, 3'b000);

    // general call off (R6) and slave mode off (R7)
    gcall_en = 1'b0;
    do_start(); send(8'h00);
    chk("R6 general call disabled", got, 3'b000);
    gcall_en = 1'b1; slave_en = 1'b0;
    do_start(); send(8'h00);
    chk("R7 general call off outside slave mode", got, 3'b000);
    mask_sel = 5'h1F;
    do_start(); send(8'hB0);
    chk("R7 masks ignored outside slave mode", got, 3'b000);
    do_start(); send(8'hB4);
    chk("R7 exact match outside slave mode", got, 3'b101);
    slave_en = 1'b1; gcall_en = 1'b0;

    // 10-bit second-byte sweep (R5)
    ten_bit = 1'b1;
    own_addr = 10'h2B5;
    for (int m = 0; m < 32; m++) begin
      mask_sel = m[4:0];
      for (int b = 0; b < 256; b++) begin
        logic [7:0] care;
        logic em;
        care = ~{2'b00, m[4:0], m[0]};
        em = (((b[7:0] ^ own_addr[7:0]) & care) == '0);
        do_start();
        send({5'b11110, own_addr[9:8], b[0]});
        chk("R5 header alone gives no match", got, 3'b000);
        send(b[7:0]);
        chk("R5 R3 10-bit second byte", got, {em, 1'b0, em});
      end
    end

    // 10-bit header sweep with full mask: header never masked (R5)
    mask_sel = 5'h1F;
    for (int h = 0; h < 256; h++) begin
      logic em;
      em = (h[7:1] == {5'b11110, own_addr[9:8]});
      do_start();
      send(h[7:0]);
      chk("R5 first byte alone", got, 3'b000);
      send(own_addr[7:0]);
      chk("R5 header compare", got, {em, 1'b0, em});
    end

    // a third byte is ignored, general call in 10-bit mode (R8 R6)
    mask_sel = '0;
    do_start(); send(8'hF4); send(8'hB5);
    chk("R5 exact 10-bit match", got, 3'b101);
    send(8'hB5);
    chk("R8 third byte ignored", got, 3'b000);
    gcall_en = 1'b1;
    do_start(); send(8'h00);
    chk("R6 general call in 10-bit mode", got, 3'b011);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule